// File: doc/BRIEF.md
# Timer Clock-Source and Stop-Mode Gate

This block controls two independent countdown timers that share one control word: a periodic-interrupt timer and a watchdog. Each timer takes its counting strobe either from an internal RC clock enable or from an external oscillator clock enable. The oscillator source can be chosen only while the oscillator is reported ready. If the oscillator is lost, the block falls back to the RC source on its own. Every change of source restarts that timer's period.

When the system enters stop, each timer normally freezes and keeps its count. In pseudo-stop, a timer keeps counting only if two things are true: its pseudo-stop enable is set, and it runs from the oscillator.

Both clocks are modelled as one-cycle enable strobes in the single `clk` domain. Each timer counts down one step per selected strobe. When it reaches zero it pulses its timeout output for one cycle and reloads from its reload input.

Top module: `tmr_src_gate`

## Requirements
- R1: A synchronous reset clears the control word, both timeout outputs and both counters. The first selected strobe after reset therefore produces a timeout on each channel.
- R2: The control word has four bits. Bit 0 is the interrupt-timer source select and bit 1 is the watchdog source select (0 = RC strobe, 1 = oscillator strobe). Bit 2 and bit 3 are the pseudo-stop enables of the interrupt timer and the watchdog. A write while `osc_ready` is 1 stores all four bits, and `ctrl_rd` shows the stored value one cycle later.
- R3: A write of 1 to a source-select bit while `osc_ready` is 0 leaves that bit at 0.
- R4: While `osc_ready` is 0, both source-select bits read 0 from the next cycle on. The pseudo-stop enables are not affected.
- R5: The pseudo-stop enable bits are written regardless of `osc_ready`.
- R6: A channel decrements once per strobe of its selected source and ignores the other source. On a strobe at zero it pulses its timeout for exactly one cycle and reloads, so the period is reload+1 strobes.
- R7: A change of a channel's source-select bit reloads that channel's counter one cycle after the new bit value becomes visible, with no timeout.
- R8: Clearing a source-select bit because the oscillator was lost also restarts that channel's period.
- R9: In full stop (`stop_mode`=1, `pstop_mode`=0) both counters hold their count, and counting resumes from that count when stop ends.
- R10: In pseudo-stop (`stop_mode`=1, `pstop_mode`=1) a channel counts only if both its pseudo-stop enable and its source-select bit are 1. Otherwise it holds its count.
- R11: The two channels follow the same rules independently, each using its own bits and reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single system clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 4 | Control word write value |
| osc_ready | input | 1 | Oscillator ready status |
| irc_tick | input | 1 | Internal RC clock enable strobe |
| osc_tick | input | 1 | Oscillator clock enable strobe |
| stop_mode | input | 1 | Stop mode active |
| pstop_mode | input | 1 | Stop is pseudo-stop (valid with stop_mode) |
| pit_reload | input | CNT_W | Interrupt-timer reload value |
| wdg_reload | input | CNT_W | Watchdog reload value |
| ctrl_rd | output | 4 | Effective control word |
| pit_timeout | output | 1 | Interrupt-timer timeout pulse |
| wdg_timeout | output | 1 | Watchdog timeout pulse |

## Verification
The write rules are tried with a table of writes that pairs each value with the ready flag high and low. This separates a blocked source bit from a pseudo-stop bit that was written normally, and it shows the fallback when the oscillator is lost. The counters are driven by strobes on the selected source mixed with strobes on the unselected one. The count is changed part-way through a period, by a source switch or by loss of the oscillator, and the strobe on which the timeout arrives shows whether a reload happened. Full stop, and pseudo-stop under each combination of enable and source, are then left part-way through a period. The number of strobes needed afterwards tells a held count from one that was reset or one that kept running.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_PIT = 0;
  localparam int CH_WDG = 1;
  localparam int CTRL_W = 2 * NUM_CH;

  typedef struct packed {
    logic [NUM_CH-1:0] pstop_en;
    logic [NUM_CH-1:0] src;
  } ctrl_t;
endpackage

// File: rtl/tsg_ctrl_reg.sv
module tsg_ctrl_reg
  import tsg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  ctrl_t             wr_data,
  input  logic              osc_ready,
  output ctrl_t             ctrl_q,
  output logic [NUM_CH-1:0] restart_q
);
  ctrl_t ctrl_nxt;

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (wr_en) ctrl_nxt = wr_data;
    // source bits survive only while the oscillator is ready
    ctrl_nxt.src = ctrl_nxt.src & {NUM_CH{osc_ready}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      restart_q <= '0;
    end else begin
      ctrl_q    <= ctrl_nxt;
      restart_q <= ctrl_nxt.src ^ ctrl_q.src;
    end
  end

  AST_SRC_NEEDS_OSC: assert property (@(posedge clk) disable iff (rst)
    (|ctrl_q.src) |-> $past(osc_ready)); // R3
  AST_LOSS_CLEARS_SRC: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(osc_ready)) |-> (ctrl_q.src == '0)); // R4
  AST_RESTART_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (ctrl_q.src != $past(ctrl_q.src))) |-> (restart_q != '0)); // R7
endmodule

// File: rtl/tsg_step_gate.sv
module tsg_step_gate (
  input  logic irc_tick,
  input  logic osc_tick,
  input  logic src,
  input  logic pstop_en,
  input  logic stop_mode,
  input  logic pstop_mode,
  output logic step
);
  logic tick_sel;
  logic awake;
  logic keep_alive;

  always_comb begin
    tick_sel   = src ? osc_tick : irc_tick;
    awake      = !stop_mode;
    keep_alive = stop_mode && pstop_mode && pstop_en && src;
    step       = tick_sel && (awake || keep_alive);
  end

  always_comb begin
    if (stop_mode && !pstop_mode)
      AST_FULL_STOP_HALTS: assert (!step); // R9
    if (stop_mode && (!pstop_en || !src))
      AST_PSTOP_NEEDS_OSC: assert (!step); // R10
  end
endmodule

// File: rtl/tsg_chan_cnt.sv
module tsg_chan_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload,
  output logic             timeout
);
  logic [CNT_W-1:0] cnt_q;
  logic             timeout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      timeout_q <= 1'b0;
    end else if (restart) begin
      cnt_q     <= reload;
      timeout_q <= 1'b0;
    end else if (step) begin
      if (cnt_q == '0) begin
        cnt_q     <= reload;
        timeout_q <= 1'b1;
      end else begin
        cnt_q     <= cnt_q - 1'b1;
        timeout_q <= 1'b0;
      end
    end else begin
      timeout_q <= 1'b0;
    end
  end

  assign timeout = timeout_q;

  AST_RELOAD_ON_RESTART: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(restart)) |-> (cnt_q == $past(reload) && !timeout_q)); // R7
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(restart) && !$past(step)) |-> ($stable(cnt_q) && !timeout_q)); // R9
  AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    timeout_q |-> ($past(step) && $past(cnt_q) == '0)); // R6
endmodule

// File: rtl/tmr_src_gate.sv
module tmr_src_gate
  import tsg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              osc_ready,
  input  logic              irc_tick,
  input  logic              osc_tick,
  input  logic              stop_mode,
  input  logic              pstop_mode,
  input  logic [CNT_W-1:0]  pit_reload,
  input  logic [CNT_W-1:0]  wdg_reload,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic              pit_timeout,
  output logic              wdg_timeout
);
  ctrl_t             ctrl_q;
  logic [NUM_CH-1:0] restart;
  logic [NUM_CH-1:0] step;
  logic [NUM_CH-1:0] timeout_vec;
  logic [CNT_W-1:0]  reload_arr [NUM_CH];

  assign reload_arr[CH_PIT] = pit_reload;
  assign reload_arr[CH_WDG] = wdg_reload;

  tsg_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (ctrl_t'(wr_data)),
    .osc_ready (osc_ready),
    .ctrl_q    (ctrl_q),
    .restart_q (restart)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tsg_step_gate u_gate (
      .irc_tick   (irc_tick),
      .osc_tick   (osc_tick),
      .src        (ctrl_q.src[c]),
      .pstop_en   (ctrl_q.pstop_en[c]),
      .stop_mode  (stop_mode),
      .pstop_mode (pstop_mode),
      .step       (step[c])
    );

    tsg_chan_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .step    (step[c]),
      .restart (restart[c]),
      .reload  (reload_arr[c]),
      .timeout (timeout_vec[c])
    );
  end

  assign ctrl_rd     = ctrl_q;
  assign pit_timeout = timeout_vec[CH_PIT];
  assign wdg_timeout = timeout_vec[CH_WDG];
endmodule

// File: tb/tmr_src_gate_bench.sv
module tmr_src_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int NVEC = 9;
  // {wr_en, wr_data[3:0], osc_ready, expected ctrl_rd[3:0]}
  localparam logic [9:0] VECS [NVEC] = '{
    {1'b1, 4'hF, 1'b0, 4'hC},  // R3 R5
    {1'b0, 4'h0, 1'b1, 4'hC},
    {1'b1, 4'hF, 1'b1, 4'hF},  // R2
    {1'b0, 4'h0, 1'b0, 4'hC},  // R4
    {1'b1, 4'h1, 1'b1, 4'h1},  // R2 R5
    {1'b1, 4'h2, 1'b1, 4'h2},
    {1'b1, 4'h3, 1'b1, 4'h3},
    {1'b0, 4'h0, 1'b0, 4'h0},  // R4
    {1'b1, 4'h0, 1'b1, 4'h0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] wr_data = '0;
  logic osc_ready = 1'b0;
  logic irc_tick = 1'b0;
  logic osc_tick = 1'b0;
  logic stop_mode = 1'b0;
  logic pstop_mode = 1'b0;
  logic [CNT_W-1:0] pit_reload = 16'd3;
  logic [CNT_W-1:0] wdg_reload = 16'd5;
  logic [3:0] ctrl_rd;
  logic pit_timeout;
  logic wdg_timeout;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_src_gate #(.CNT_W(CNT_W)) u_tmr_src_gate (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .osc_ready(osc_ready),
    .irc_tick(irc_tick), .osc_tick(osc_tick), .stop_mode(stop_mode),
    .pstop_mode(pstop_mode), .pit_reload(pit_reload), .wdg_reload(wdg_reload),
    .ctrl_rd(ctrl_rd), .pit_timeout(pit_timeout), .wdg_timeout(wdg_timeout)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic i, input logic o);
    irc_tick = i;
    osc_tick = o;
    @(negedge clk);
    irc_tick = 1'b0;
    osc_tick = 1'b0;
  endtask

  task automatic write_ctrl(input logic [3:0] v);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R6: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 ctrl", ctrl_rd, 4'h0);
    check("R1 pit", pit_timeout, 1'b0);
    check("R1 wdg", wdg_timeout, 1'b0);
    // first strobe after reset fires both, counters reload
    tick(1, 0);
    check("R1 pit first", pit_timeout, 1'b1);
    check("R1 wdg first", wdg_timeout, 1'b1);
    for (int k = 0; k < 3; k++) begin
      tick(1, 0);
      check("R6 pit counting", pit_timeout, 1'b0);
    end
    tick(1, 0);
    check("R6 pit period", pit_timeout, 1'b1);
    @(negedge clk);
    check("R6 one cycle", pit_timeout, 1'b0);
    for (int k = 0; k < 3; k++) begin
      tick(0, 1);
      check("R6 other source ignored", wdg_timeout, 1'b0);
    end
    tick(1, 0);
    check("R6 wdg counting", wdg_timeout, 1'b0);
    tick(1, 0);
    check("R11 wdg period", wdg_timeout, 1'b1);

    // control word write rules
    for (int i = 0; i < NVEC; i++) begin
      wr_en = VECS[i][9];
      wr_data = VECS[i][8:5];
      osc_ready = VECS[i][4];
      @(negedge clk);
      wr_en = 1'b0;
      check("R2 R3 R4 R5 table", ctrl_rd, VECS[i][3:0]);
    end
    osc_ready = 1'b1;
    @(negedge clk);

    // source switch restarts
    write_ctrl(4'h1);
    for (int k = 0; k < 3; k++) begin
      tick(1, 1);
      check("R7 osc count", pit_timeout, 1'b0);
    end
    tick(0, 1);
    check("R6 osc selected", pit_timeout, 1'b1);
    tick(0, 1);
    tick(0, 1);
    write_ctrl(4'h0);
    for (int k = 0; k < 3; k++) begin
      tick(1, 0);
      check("R7 restarted", pit_timeout, 1'b0);
    end
    tick(1, 0);
    check("R7 full period", pit_timeout, 1'b1);

    // oscillator loss restarts
    write_ctrl(4'h1);
    tick(0, 1);
    tick(0, 1);
    osc_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R4 loss clears", ctrl_rd, 4'h0);
    osc_ready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick(1, 0);
      check("R8 restarted", pit_timeout, 1'b0);
    end
    tick(1, 0);
    check("R8 full period", pit_timeout, 1'b1);

    // full stop holds
    write_ctrl(4'h1);
    write_ctrl(4'h0);
    tick(1, 0);
    tick(1, 0);
    stop_mode = 1'b1;
    for (int k = 0; k < 5; k++) begin
      tick(1, 1);
      check("R9 held", pit_timeout, 1'b0);
    end
    stop_mode = 1'b0;
    tick(1, 0);
    check("R9 resume", pit_timeout, 1'b0);
    tick(1, 0);
    check("R9 count kept", pit_timeout, 1'b1);

    // pseudo-stop
    write_ctrl(4'h5);
    stop_mode = 1'b1;
    pstop_mode = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick(0, 1);
      check("R10 running", pit_timeout, 1'b0);
    end
    tick(0, 1);
    check("R10 runs in pseudo-stop", pit_timeout, 1'b1);
    write_ctrl(4'h1);
    for (int k = 0; k < 4; k++) begin
      tick(0, 1);
      check("R10 enable off holds", pit_timeout, 1'b0);
    end
    write_ctrl(4'h4);
    for (int k = 0; k < 4; k++) begin
      tick(1, 0);
      check("R10 rc source holds", pit_timeout, 1'b0);
    end
    stop_mode = 1'b0;
    pstop_mode = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick(1, 0);
      check("R10 resume", pit_timeout, 1'b0);
    end
    tick(1, 0);
    check("R10 count kept", pit_timeout, 1'b1);

    // watchdog channel in pseudo-stop, interrupt timer held
    write_ctrl(4'hE);
    check("R11 ctrl", ctrl_rd, 4'hE);
    stop_mode = 1'b1;
    pstop_mode = 1'b1;
    for (int k = 0; k < 5; k++) begin
      tick(1, 1);
      check("R11 wdg counting", wdg_timeout, 1'b0);
      check("R11 pit held", pit_timeout, 1'b0);
    end
    tick(0, 1);
    check("R11 wdg fires", wdg_timeout, 1'b1);
    check("R11 pit quiet", pit_timeout, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule